// File: doc/BRIEF.md
# Serial DAC Input Register

This block is the digital front end of a voltage-output converter. It accepts a three-wire serial stream made of an active-low frame select, a serial clock and a data line. All three pins are sampled by a faster system clock through two-flop synchronisers, and edges are detected in the system clock domain. While the frame select is low, each rising serial clock edge shifts one bit into a 16-bit shift register, most significant bit first. When the frame select rises, the shifted word is moved into the converter latch.

A frame must carry at least 16 serial clock edges. If it carries more, the last 16 bits received are the ones latched. If it carries fewer, the latch keeps its old value and a sticky error flag is raised. The next good frame clears that flag. For 14-bit and 12-bit builds, the code is the upper part of the 16-bit word and the trailing bits are ignored. Each latch load produces a one-cycle strobe.

Top module: `serdac_front`

## Requirements
- R1: After reset, `code_out` is 0, `short_err` is 0 and `update_pulse` is 0. Reset also makes the serial interface idle, so a frame that was cut off by reset has no effect.
- R2: While `sel_n_in` is low, each rising edge of `sck_in` samples `sdi_in`, with the first bit sampled being the word's bit 15. A frame of exactly 16 rising edges, closed by a rising `sel_n_in`, loads that 16-bit word.
- R3: `code_out` changes only when the latch loads after a rising edge of `sel_n_in`. It holds its old value throughout a frame, even once 16 bits have arrived.
- R4: A frame with more than 16 rising `sck_in` edges loads only the last 16 bits received.
- R5: A frame with fewer than 16 rising `sck_in` edges, including zero edges, leaves `code_out` unchanged. It sets `short_err` to 1 and produces no `update_pulse`.
- R6: `short_err` stays set until the next frame of at least 16 edges, which clears it to 0 at the same time it loads the latch.
- R7: While `sel_n_in` is high, activity on `sck_in` and `sdi_in` changes neither `code_out` nor `short_err`, and produces no `update_pulse`.
- R8: When `RES_BITS` is below 16, `code_out` equals bits 15 down to 16-`RES_BITS` of the received word, and the lower bits are don't-care.
- R9: Each latch load raises `update_pulse` for exactly one system clock cycle, in the same cycle that `code_out` takes its new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n_in | input | 1 | Asynchronous frame select, active low |
| sck_in | input | 1 | Asynchronous serial clock |
| sdi_in | input | 1 | Asynchronous serial data |
| code_out | output | RES_BITS | Latched converter code |
| update_pulse | output | 1 | One-cycle strobe when the latch loads |
| short_err | output | 1 | Sticky flag for a frame with too few clocks |

## Verification
The hardest situations to reach are those where the shift register holds stale bits: a frame that is too long, a frame that is too short, and a frame cut off by reset. In each case the latched result has to show that only the right bits counted. The stimulus table mixes 16-edge, 20-edge and 32-edge frames with short frames of 10 edges and of zero edges. The expected code is computed from the low 16 bits of each stream. Directed tests then toggle the serial pins while the frame is deselected, and assert reset in the middle of a frame. A second instance built for 12 bits receives the same streams, so left justification is checked against the same words.

// File: rtl/serdac_pkg.sv
// Shared constants and types for the serial DAC input register.
// Assumes: the serial word is always 16 bits, whatever the code resolution.
package serdac_pkg;
    localparam int WORD_BITS = 16;

    // Synchronised view of one asynchronous pin.
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pin_view_t;
endpackage

// File: rtl/serdac_sync.sv
// Multi-flop synchroniser followed by an edge detector for one pin.
// Assumes: the pin is stable for more than one clk period between changes.
// The reset value matches the pin's idle level, so release of reset creates no edge.
module serdac_sync #(
    parameter int   STAGES  = 2,
    parameter logic IDLE    = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pin,
    output serdac_pkg::pin_view_t  view
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the raw pin through the synchroniser and the edge-history stage.
    genvar g;
    generate
        for (g = 0; g < CHAIN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= IDLE;
                    else        chain_q[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= IDLE;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Expose the synchronised level and its single-cycle edges.
    always_comb begin
        view.level = chain_q[STAGES-1];
        view.rise  = chain_q[STAGES-1] & ~chain_q[STAGES];
        view.fall  = ~chain_q[STAGES-1] & chain_q[STAGES];
    end
endmodule

// File: rtl/serdac_shifter.sv
// Serial shift register with a saturating bit counter.
// Shifts MSB first on each serial clock rise while the frame is selected.
// The counter restarts at each frame start and saturates at the word width.
module serdac_shifter #(
    parameter int WORD_BITS = serdac_pkg::WORD_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_level,
    input  logic                 sel_fall,
    input  logic                 sck_rise,
    input  logic                 sdi_level,
    output logic [WORD_BITS-1:0] word,
    output logic                 full
);
    localparam int CNT_W = $clog2(WORD_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_BITS);

    logic [WORD_BITS-1:0] shreg_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 shift_en;

    // A bit is taken only on a clock rise inside a selected frame.
    assign shift_en = sck_rise & ~sel_level & ~sel_fall;

    // Hold the received bits; the oldest bits fall off the top.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg_q <= '0;
        else if (shift_en) shreg_q <= {shreg_q[WORD_BITS-2:0], sdi_level};
    end

    // Count the clock rises of the current frame, stopping at the word width.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (sel_fall)                    cnt_q <= '0;
        else if (shift_en && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign word = shreg_q;
    assign full = (cnt_q == CNT_MAX);
endmodule

// File: rtl/serdac_latch.sv
// DAC code latch with update strobe and sticky short-frame flag.
// Assumes: frame_end is a one-cycle pulse; frame_ok is valid in that cycle.
// Keeps the upper RES_BITS of the received word.
module serdac_latch #(
    parameter int WORD_BITS = serdac_pkg::WORD_BITS,
    parameter int RES_BITS  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_end,
    input  logic                 frame_ok,
    input  logic [WORD_BITS-1:0] word,
    output logic [RES_BITS-1:0]  code,
    output logic                 strobe,
    output logic                 err
);
    localparam int LSB = WORD_BITS - RES_BITS;

    logic [RES_BITS-1:0] code_q;
    logic                strobe_q;
    logic                err_q;
    logic                load;

    assign load = frame_end & frame_ok;

    // Capture the left-justified code when a complete frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n)    code_q <= '0;
        else if (load) code_q <= word[WORD_BITS-1:LSB];
    end

    // Pulse once per load.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= load;
    end

    // Set on a short frame, clear on the next complete one.
    always_ff @(posedge clk) begin
        if (!rst_n)         err_q <= 1'b0;
        else if (frame_end) err_q <= ~frame_ok;
    end

    assign code   = code_q;
    assign strobe = strobe_q;
    assign err    = err_q;
endmodule

// File: rtl/serdac_front.sv
// Top of the serial DAC input register.
// Synchronises the three serial pins, shifts the frame and loads the latch
// when the frame select rises. Assumes clk is several times faster than the
// serial clock, and that sdi_in is stable around each serial clock rise.
module serdac_front #(
    parameter int RES_BITS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_n_in,
    input  logic                sck_in,
    input  logic                sdi_in,
    output logic [RES_BITS-1:0] code_out,
    output logic                update_pulse,
    output logic                short_err
);
    import serdac_pkg::*;

    pin_view_t            sel_v;
    pin_view_t            sck_v;
    pin_view_t            sdi_v;
    logic [WORD_BITS-1:0] word;
    logic                 full;

    serdac_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync_sel (
        .clk(clk), .rst_n(rst_n), .pin(sel_n_in), .view(sel_v)
    );
    serdac_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .pin(sck_in), .view(sck_v)
    );
    serdac_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_sync_sdi (
        .clk(clk), .rst_n(rst_n), .pin(sdi_in), .view(sdi_v)
    );

    serdac_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_level (sel_v.level),
        .sel_fall  (sel_v.fall),
        .sck_rise  (sck_v.rise),
        .sdi_level (sdi_v.level),
        .word      (word),
        .full      (full)
    );

    serdac_latch #(.WORD_BITS(WORD_BITS), .RES_BITS(RES_BITS)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (sel_v.rise),
        .frame_ok  (full),
        .word      (word),
        .code      (code_out),
        .strobe    (update_pulse),
        .err       (short_err)
    );
endmodule

// File: rtl/serdac_front_chk.sv
// Assertion checker for serdac_front, attached by bind below.
// Observes only the top-level ports.
module serdac_front_chk #(
    parameter int RES_BITS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [RES_BITS-1:0] code_out,
    input logic                update_pulse,
    input logic                short_err
);
    // R9: the strobe never lasts two cycles.
    a_r9_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        update_pulse |=> !update_pulse);

    // R3: the code moves only in a strobe cycle.
    a_r3_code_moves_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_out) |-> update_pulse);

    // R6: a load leaves the error flag clear.
    a_r6_load_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
        update_pulse |-> !short_err);

    // R5: a short frame raises the flag without a strobe.
    a_r5_short_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(short_err) |-> !update_pulse);

    // R5: while the flag is newly set, the code holds.
    a_r5_short_holds_code: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(short_err) |-> $stable(code_out));
endmodule

bind serdac_front serdac_front_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .code_out     (code_out),
    .update_pulse (update_pulse),
    .short_err    (short_err)
);

// File: tb/serdac_front_tb_top.sv
module serdac_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic [15:0] code16;
    logic [11:0] code12;
    logic        pulse16, pulse12;
    logic        err16, err12;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    int wide = 0;
    bit done = 0;
    logic prev_pulse = 1'b0;

    always #2.5 clk = ~clk;

    serdac_front #(.RES_BITS(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n_in(sel_n), .sck_in(sck), .sdi_in(sdi),
        .code_out(code16), .update_pulse(pulse16), .short_err(err16)
    );

    serdac_front #(.RES_BITS(12)) dut12_i (
        .clk(clk), .rst_n(rst_n), .sel_n_in(sel_n), .sck_in(sck), .sdi_in(sdi),
        .code_out(code12), .update_pulse(pulse12), .short_err(err12)
    );

    // Count strobe cycles and strobes longer than one cycle.
    always @(posedge clk) begin
        if (pulse16) pulses <= pulses + 1;
        if (pulse16 && prev_pulse) wide <= wide + 1;
        prev_pulse <= pulse16;
    end

    localparam int NVEC = 8;
    localparam logic [31:0] VEC_WORD [NVEC] = '{
        32'h0000_A5C3, 32'h0000_1234, 32'h000B_7E19, 32'h0000_03FF,
        32'h0000_0001, 32'hDEAD_BEEF, 32'h0000_0000, 32'h0000_8000
    };
    localparam int VEC_LEN [NVEC] = '{16, 16, 20, 10, 16, 32, 0, 16};

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Send len bits of data, MSB first; check the code holds before the select rises.
    task automatic send_frame(input logic [31:0] data, input int len, input logic [15:0] hold16);
        sel_n = 1'b0;
        tick(4);
        for (int i = len - 1; i >= 0; i--) begin
            sdi = data[i];
            sck = 1'b0;
            tick(3);
            sck = 1'b1;
            tick(3);
        end
        sck = 1'b0;
        tick(4);
        check("R3 code held inside frame", 32'(code16), 32'(hold16));
        sel_n = 1'b1;
        tick(8);
    endtask

    initial begin
        logic [15:0] exp16;
        logic [11:0] exp12;
        logic        exp_err;
        int          p0;

        tick(5);
        check("R1 reset code", 32'(code16), 0);
        check("R1 reset err", 32'(err16), 0);
        check("R1 reset strobe", 32'(pulse16), 0);
        rst_n = 1'b1;
        tick(5);

        exp16 = '0; exp12 = '0; exp_err = 1'b0;
        for (int v = 0; v < NVEC; v++) begin
            p0 = pulses;
            send_frame(VEC_WORD[v], VEC_LEN[v], exp16);
            if (VEC_LEN[v] >= 16) begin
                exp16 = VEC_WORD[v][15:0];
                exp12 = VEC_WORD[v][15:4];
                exp_err = 1'b0;
            end else begin
                exp_err = 1'b1;
            end
            check(VEC_LEN[v] > 16 ? "R4 long frame code" :
                  VEC_LEN[v] < 16 ? "R5 short frame code held" : "R2 frame code",
                  32'(code16), 32'(exp16));
            check(VEC_LEN[v] < 16 ? "R5 short flag set" : "R6 flag clear after good frame",
                  32'(err16), 32'(exp_err));
            check("R9 one strobe per load", 32'(pulses - p0), VEC_LEN[v] >= 16 ? 1 : 0);
            check("R8 12-bit left-justified code", 32'(code12), 32'(exp12));
            check("R8 12-bit flag", 32'(err12), 32'(exp_err));
        end
        check("R9 strobe width one cycle", 32'(wide), 0);

        // R7: activity while deselected is ignored.
        p0 = pulses;
        for (int i = 0; i < 20; i++) begin
            sdi = i[0] ^ i[2];
            sck = 1'b1;
            tick(3);
            sck = 1'b0;
            tick(3);
        end
        tick(8);
        check("R7 deselected code", 32'(code16), 32'(exp16));
        check("R7 deselected err", 32'(err16), 32'(exp_err));
        check("R7 deselected strobe", 32'(pulses - p0), 0);

        // R1: reset in the middle of a frame.
        sel_n = 1'b0;
        tick(4);
        for (int i = 0; i < 10; i++) begin
            sdi = 1'b1;
            sck = 1'b1;
            tick(3);
            sck = 1'b0;
            tick(3);
        end
        rst_n = 1'b0;
        tick(3);
        check("R1 mid-frame reset code", 32'(code16), 0);
        check("R1 mid-frame reset err", 32'(err16), 0);
        sel_n = 1'b1;
        tick(3);
        rst_n = 1'b1;
        tick(8);
        check("R1 no load after reset", 32'(code16), 0);
        send_frame(32'h0000_C0DE, 16, 16'h0000);
        check("R2 frame after reset", 32'(code16), 32'h0000_C0DE);
        check("R8 frame after reset 12-bit", 32'(code12), 32'h0000_0C0D);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule